// File: doc/BRIEF.md
# Two-Level Radio Interrupt Flag Controller

This block gathers eight radio-side events into an 8-bit pending-flag register. Each flag has a matching bit in an enable-mask register. The OR of all flags that are both set and enabled drives a single CPU-level pending bit. That pending bit has its own clear input, separate from the flag register. Software therefore retires an interrupt in two steps: it clears the flag here, and it clears the CPU-level pending bit.

Two of the eight events are derived inside the block:

- **RX-enable-dropped.** The RX enable vector changes from a nonzero value to zero.
- **FIFO-level.** Any of three conditions fires:
  - the FIFO byte count rises past a programmable threshold;
  - a complete frame arrives;
  - a packet has been read out while more complete packets remain stored.

A byte-wide register port gives access to both registers. Flags are read and are cleared by writing zero. The mask is read and written in the ordinary way.

The pending bit is a two-state machine:

- **IRQ_IDLE** moves to **IRQ_PEND** on a trigger. A trigger is either a rising edge of the enabled-flag OR, or any write to the flag register that leaves the enabled-flag OR true.
- **IRQ_PEND** returns to **IRQ_IDLE** when `cpu_clr` is high and no trigger is present in the same cycle.
- **IRQ_PEND** stays in place in every other case.

Top module: `rif_ctrl`

## Requirements
- R1: After reset the flag register reads 0x00, the mask register reads 0x00 and `irq_pending` is 0.
- R2: An event input sets its flag one clock after it is sampled high, whatever the mask holds. Bit map: 7 RX-enable-dropped, 6 packet done (`ev_pkt_done`), 5 frame accepted (`ev_frame_ok`), 4 source hit (`ev_src_hit`), 3 source search end (`ev_src_end`), 2 FIFO-level, 1 SFD (`ev_sfd`), 0 activity (`ev_act`).
- R3: With `reg_sel`=0 the port reads the flags. A flag write clears each bit written 0 and leaves each bit written 1 unchanged, so software can never set a flag.
- R4: With `reg_sel`=1 the port writes the mask, and reading returns the written value.
- R5: When an event and a clearing write hit the same flag in the same cycle, the flag ends up 1.
- R6: Flag bit 7 sets only when `rx_en` goes from nonzero to zero. A change from zero to nonzero, or from nonzero to another nonzero value, has no effect.
- R7: Flag bit 2 sets in any of these cases:
  - on a clock where `fifo_cnt` > `fifo_thr` holds and did not hold the clock before (count equal to the threshold does not count);
  - on `ev_pkt_done`;
  - on `pkt_read` together with `more_pkts`.
  
  `pkt_read` without `more_pkts` has no effect.
- R8: `irq_pending` rises one clock after the OR of (flags AND mask) rises, including when a mask write enables an already-set flag. A set flag whose mask bit is 0 never raises it.
- R9: `irq_pending` falls only through `cpu_clr`. Clearing flags does not drop it, and `cpu_clr` loses to a trigger in the same cycle. Without a write, an enabled flag that stays set does not re-raise it.
- R10: A flag write that leaves any enabled flag set raises `irq_pending` one clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ev_pkt_done | input | 1 | Complete packet received pulse |
| ev_frame_ok | input | 1 | Frame accepted pulse |
| ev_src_hit | input | 1 | Source match hit pulse |
| ev_src_end | input | 1 | Source search finished pulse |
| ev_sfd | input | 1 | Start-of-frame delimiter pulse |
| ev_act | input | 1 | Activity (spare) pulse |
| rx_en | input | EN_W | RX enable vector |
| fifo_cnt | input | CNT_W | RX FIFO byte count |
| fifo_thr | input | CNT_W | FIFO threshold |
| pkt_read | input | 1 | A packet has been fully read out |
| more_pkts | input | 1 | More complete packets remain stored |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects flags, 1 selects mask |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data of the selected register |
| cpu_clr | input | 1 | Clear for the CPU-level pending bit |
| irq_pending | output | 1 | CPU-level pending bit (registered) |

## Verification
The hardest case to reach is `cpu_clr` arriving in the same clock as a fresh trigger, where the trigger must win.

The bench first parks the machine in IRQ_PEND with an enabled flag set. It then masks that flag off and enables it again. The mask write makes the enabled-flag OR rise on a known edge, and `cpu_clr` is asserted in exactly the following cycle, which is when the trigger is present.

The bench also checks the re-arm path of R10. After `cpu_clr`, it first confirms that `irq_pending` stays low while enabled flags remain set. Only then does it issue a partial clearing write and confirm that `irq_pending` rises.

// File: rtl/rif_pkg.sv
package rif_pkg;
    localparam int REG_W   = 8;
    localparam int B_RXOFF = 7;
    localparam int B_PKT   = 6;
    localparam int B_FRM   = 5;
    localparam int B_SHIT  = 4;
    localparam int B_SEND  = 3;
    localparam int B_FIFO  = 2;
    localparam int B_SFD   = 1;
    localparam int B_ACT   = 0;

    typedef enum logic {
        SEL_FLAGS = 1'b0,
        SEL_MASK  = 1'b1
    } reg_sel_e;

    typedef enum logic {
        IRQ_IDLE = 1'b0,
        IRQ_PEND = 1'b1
    } irq_state_e;
endpackage

// File: rtl/rif_event_gen.sv
module rif_event_gen
    import rif_pkg::*;
#(
    parameter int EN_W  = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_pkt_done,
    input  logic             ev_frame_ok,
    input  logic             ev_src_hit,
    input  logic             ev_src_end,
    input  logic             ev_sfd,
    input  logic             ev_act,
    input  logic [EN_W-1:0]  rx_en,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic [CNT_W-1:0] fifo_thr,
    input  logic             pkt_read,
    input  logic             more_pkts,
    output logic [REG_W-1:0] evt_vec
);
    logic [EN_W-1:0] rx_prev_q;
    logic            above_q;
    logic            above;
    logic            rx_drop;
    logic            fifo_evt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_prev_q <= '0;
            above_q   <= 1'b0;
        end else begin
            rx_prev_q <= rx_en;
            above_q   <= above;
        end
    end

    always_comb begin
        above    = fifo_cnt > fifo_thr;
        rx_drop  = (|rx_prev_q) && !(|rx_en);
        fifo_evt = (above && !above_q) || ev_pkt_done || (pkt_read && more_pkts);
        evt_vec          = '0;
        evt_vec[B_RXOFF] = rx_drop;
        evt_vec[B_PKT]   = ev_pkt_done;
        evt_vec[B_FRM]   = ev_frame_ok;
        evt_vec[B_SHIT]  = ev_src_hit;
        evt_vec[B_SEND]  = ev_src_end;
        evt_vec[B_FIFO]  = fifo_evt;
        evt_vec[B_SFD]   = ev_sfd;
        evt_vec[B_ACT]   = ev_act;
    end
endmodule

// File: rtl/rif_flag_bank.sv
module rif_flag_bank
    import rif_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt_vec,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] flag_q,
    output logic [REG_W-1:0] mask_q,
    output logic             flag_wr_q
);
    logic flag_wr;
    logic mask_wr;

    assign flag_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_FLAGS);
    assign mask_wr = reg_wr && (reg_sel_e'(reg_sel) == SEL_MASK);

    for (genvar i = 0; i < REG_W; i++) begin : g_flag
        logic clr_bit;
        assign clr_bit = flag_wr && !reg_wdata[i];
        always_ff @(posedge clk) begin
            if (!rst_n) flag_q[i] <= 1'b0;
            else        flag_q[i] <= evt_vec[i] || (flag_q[i] && !clr_bit);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q    <= '0;
            flag_wr_q <= 1'b0;
        end else begin
            if (mask_wr) mask_q <= reg_wdata;
            flag_wr_q <= flag_wr;
        end
    end
endmodule

// File: rtl/rif_irq_fsm.sv
module rif_irq_fsm
    import rif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic irq_active,
    input  logic flag_wr_q,
    input  logic cpu_clr,
    output logic irq_pending
);
    irq_state_e state_q, state_d;
    logic       active_q;
    logic       trigger;

    assign trigger = irq_active && (!active_q || flag_wr_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= IRQ_IDLE;
            active_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            active_q <= irq_active;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: if (trigger)              state_d = IRQ_PEND;
            IRQ_PEND: if (cpu_clr && !trigger)  state_d = IRQ_IDLE;
            default:                            state_d = IRQ_IDLE;
        endcase
    end

    always_comb begin
        irq_pending = (state_q == IRQ_PEND);
    end
endmodule

// File: rtl/rif_ctrl.sv
module rif_ctrl
    import rif_pkg::*;
#(
    parameter int EN_W  = 8,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev_pkt_done,
    input  logic             ev_frame_ok,
    input  logic             ev_src_hit,
    input  logic             ev_src_end,
    input  logic             ev_sfd,
    input  logic             ev_act,
    input  logic [EN_W-1:0]  rx_en,
    input  logic [CNT_W-1:0] fifo_cnt,
    input  logic [CNT_W-1:0] fifo_thr,
    input  logic             pkt_read,
    input  logic             more_pkts,
    input  logic             reg_wr,
    input  logic             reg_sel,
    input  logic [7:0]       reg_wdata,
    output logic [7:0]       reg_rdata,
    input  logic             cpu_clr,
    output logic             irq_pending
);
    logic [REG_W-1:0] evt_vec;
    logic [REG_W-1:0] flag_q;
    logic [REG_W-1:0] mask_q;
    logic             flag_wr_q;
    logic             irq_active;

    rif_event_gen #(.EN_W(EN_W), .CNT_W(CNT_W)) u_evt (
        .clk(clk), .rst_n(rst_n),
        .ev_pkt_done(ev_pkt_done), .ev_frame_ok(ev_frame_ok),
        .ev_src_hit(ev_src_hit), .ev_src_end(ev_src_end),
        .ev_sfd(ev_sfd), .ev_act(ev_act),
        .rx_en(rx_en), .fifo_cnt(fifo_cnt), .fifo_thr(fifo_thr),
        .pkt_read(pkt_read), .more_pkts(more_pkts),
        .evt_vec(evt_vec)
    );

    rif_flag_bank u_bank (
        .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .flag_q(flag_q), .mask_q(mask_q), .flag_wr_q(flag_wr_q)
    );

    assign irq_active = |(flag_q & mask_q);

    rif_irq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .irq_active(irq_active),
        .flag_wr_q(flag_wr_q), .cpu_clr(cpu_clr), .irq_pending(irq_pending)
    );

    assign reg_rdata = (reg_sel_e'(reg_sel) == SEL_MASK) ? mask_q : flag_q;
endmodule

// File: rtl/rif_ctrl_chk.sv
module rif_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] evt_vec,
    input logic [7:0] flag_q,
    input logic       irq_active,
    input logic       cpu_clr,
    input logic       irq_pending
);
    p_evt_sets_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_vec != 8'h00) |=> ((flag_q & $past(evt_vec)) == $past(evt_vec)));

    p_no_sw_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q) & ~$past(evt_vec)) == 8'h00));

    p_rise_raises_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_active) |=> irq_pending);

    p_irq_needs_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pending) |-> $past(irq_active));

    p_irq_falls_on_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_pending) |-> $past(cpu_clr));
endmodule

bind rif_ctrl rif_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .evt_vec(evt_vec), .flag_q(flag_q),
    .irq_active(irq_active), .cpu_clr(cpu_clr), .irq_pending(irq_pending)
);

// File: tb/rif_ctrl_bench.sv
`timescale 1ns/1ps
module rif_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_pkt_done = 0, ev_frame_ok = 0, ev_src_hit = 0, ev_src_end = 0;
    logic       ev_sfd = 0, ev_act = 0, pkt_read = 0, more_pkts = 0;
    logic [7:0] rx_en = 0, fifo_cnt = 0, fifo_thr = 8'hFF;
    logic       reg_wr = 0, reg_sel = 0, cpu_clr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       irq_pending;
    int         n_tests = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    rif_ctrl u_rif_ctrl (
        .clk(clk), .rst_n(rst_n),
        .ev_pkt_done(ev_pkt_done), .ev_frame_ok(ev_frame_ok),
        .ev_src_hit(ev_src_hit), .ev_src_end(ev_src_end),
        .ev_sfd(ev_sfd), .ev_act(ev_act),
        .rx_en(rx_en), .fifo_cnt(fifo_cnt), .fifo_thr(fifo_thr),
        .pkt_read(pkt_read), .more_pkts(more_pkts),
        .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .cpu_clr(cpu_clr), .irq_pending(irq_pending)
    );

    // {events, mask, expected flags, expected irq}; event bit 2 unused (derived)
    localparam logic [24:0] VEC [6] = '{
        {8'h40, 8'h00, 8'h44, 1'b0},
        {8'h02, 8'h02, 8'h02, 1'b1},
        {8'h21, 8'h10, 8'h21, 1'b0},
        {8'h18, 8'h08, 8'h18, 1'b1},
        {8'h7B, 8'h04, 8'h7F, 1'b1},
        {8'h00, 8'hFF, 8'h00, 1'b0}
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic sel, output logic [7:0] v);
        reg_sel = sel;
        #1 v = reg_rdata;
    endtask

    task automatic wr(input logic sel, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_sel = sel; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic drive_ev(input logic [7:0] v);
        ev_pkt_done = v[6]; ev_frame_ok = v[5]; ev_src_hit = v[4];
        ev_src_end = v[3]; ev_sfd = v[1]; ev_act = v[0];
    endtask

    task automatic pulse_ev(input logic [7:0] v);
        @(negedge clk); drive_ev(v);
        @(negedge clk); drive_ev(8'h00);
    endtask

    task automatic pulse_clr();
        @(negedge clk); cpu_clr = 1;
        @(negedge clk); cpu_clr = 0;
    endtask

    task automatic quiesce();
        wr(0, 8'h00); pulse_clr(); wr(1, 8'h00);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        rd(0, v); check("R1 flags reset", v, 8'h00);
        rd(1, v); check("R1 mask reset", v, 8'h00);
        check("R1 irq reset", {7'b0, irq_pending}, 8'h00);

        // table walk: R2 event latching regardless of mask, R8 aggregation
        for (int i = 0; i < 6; i++) begin
            quiesce();
            wr(1, VEC[i][16:9]);
            pulse_ev(VEC[i][24:17]);
            rd(0, v); check($sformatf("R2 vec%0d flags", i), v, VEC[i][8:1]);
            @(negedge clk);
            check($sformatf("R8 vec%0d irq", i), {7'b0, irq_pending}, {7'b0, VEC[i][0]});
        end

        // R3: writing ones cannot set, zeros clear selectively
        quiesce();
        wr(0, 8'hFF); rd(0, v); check("R3 write ones no set", v, 8'h00);
        pulse_ev(8'h42);
        rd(0, v); check("R3 setup", v, 8'h46);
        wr(0, 8'hFB); rd(0, v); check("R3 clear bit2 only", v, 8'h42);

        // R4: mask readback
        wr(1, 8'hA5); rd(1, v); check("R4 mask readback", v, 8'hA5);

        // R5: event beats clear
        quiesce();
        pulse_ev(8'h02);
        @(negedge clk);
        reg_wr = 1; reg_sel = 0; reg_wdata = 8'h00; ev_sfd = 1;
        @(negedge clk);
        reg_wr = 0; ev_sfd = 0;
        rd(0, v); check("R5 event wins", v, 8'h02);

        // R6: RX enable drop
        quiesce();
        @(negedge clk); rx_en = 8'h10;
        @(negedge clk); rx_en = 8'h03;
        @(negedge clk); rd(0, v); check("R6 nonzero changes", v, 8'h00);
        rx_en = 8'h00;
        @(negedge clk); rd(0, v); check("R6 drop to zero", v, 8'h80);
        wr(0, 8'h00); @(negedge clk);
        rd(0, v); check("R6 zero stays zero", v, 8'h00);

        // R7: FIFO-level conditions
        fifo_thr = 8'd10; fifo_cnt = 8'd10;
        @(negedge clk); @(negedge clk);
        rd(0, v); check("R7 equal not above", v, 8'h00);
        fifo_cnt = 8'd11;
        @(negedge clk); rd(0, v); check("R7 crossing", v, 8'h04);
        wr(0, 8'h00); fifo_cnt = 8'd12;
        @(negedge clk); rd(0, v); check("R7 stays above", v, 8'h00);
        fifo_cnt = 8'd5; @(negedge clk); fifo_cnt = 8'd11;
        @(negedge clk); rd(0, v); check("R7 recross", v, 8'h04);
        wr(0, 8'h00); fifo_cnt = 8'd0;
        @(negedge clk); pkt_read = 1; @(negedge clk); pkt_read = 0;
        rd(0, v); check("R7 read no more", v, 8'h00);
        more_pkts = 1; pkt_read = 1; @(negedge clk); pkt_read = 0; more_pkts = 0;
        rd(0, v); check("R7 read with more", v, 8'h04);

        // R8: masked flag silent, later enable raises
        quiesce();
        pulse_ev(8'h02);
        @(negedge clk); @(negedge clk);
        check("R8 masked silent", {7'b0, irq_pending}, 8'h00);
        wr(1, 8'h02);
        @(negedge clk);
        check("R8 enable raises", {7'b0, irq_pending}, 8'h01);

        // R9: flag clear keeps pending; cpu_clr drops; idle clr ignored
        wr(0, 8'h00); @(negedge clk);
        check("R9 held after flag clear", {7'b0, irq_pending}, 8'h01);
        pulse_clr();
        check("R9 cpu_clr drops", {7'b0, irq_pending}, 8'h00);
        pulse_clr();
        check("R9 idle clr ignored", {7'b0, irq_pending}, 8'h00);

        // R9: trigger beats cpu_clr in the same cycle
        pulse_ev(8'h02);
        @(negedge clk);
        check("R9 setup pend", {7'b0, irq_pending}, 8'h01);
        wr(1, 8'h00); wr(1, 8'h02);
        cpu_clr = 1; @(negedge clk); cpu_clr = 0;
        check("R9 trigger beats clr", {7'b0, irq_pending}, 8'h01);

        // R10: re-raise after partial clear
        quiesce();
        wr(1, 8'h42);
        pulse_ev(8'h42);
        @(negedge clk);
        pulse_clr();
        @(negedge clk); @(negedge clk);
        check("R9 no rearm without write", {7'b0, irq_pending}, 8'h00);
        wr(0, 8'hBF);
        @(negedge clk);
        check("R10 rearm on partial clear", {7'b0, irq_pending}, 8'h01);
        pulse_clr();
        wr(0, 8'hFD);
        @(negedge clk);
        check("R10 no rearm when empty", {7'b0, irq_pending}, 8'h00);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule